// File: doc/BRIEF.md
# Level-Priority Interrupt Arbiter

This block collects interrupt request lines and reports which pending, unmasked request the processor core should service next. Seven external lines sit at fixed levels one to seven. The remaining sources, numbered eight to sixty-three, each carry a programmable three-bit level and a three-bit priority. Arbitration compares levels first and priorities second. Each external line ranks halfway inside its level: above programmable priorities zero to three and below four to seven.

The block gives the core the level of the current winner through a register. Two combinational acknowledge outputs answer vector queries. One returns the winner inside a level the caller selects. The other returns the winner across the whole block. A vector is 64 plus the source number. When nothing qualifies, the spurious value 24 (0x18) is returned. A small write port programs source settings, per-source masks and a global mask. A combinational read port shows the settings of one source.

Requests are level-sensitive. A source counts as pending only while its input line is high, and the block keeps no memory of earlier requests.

Top module: `lpia_top`

## Requirements
- R1: After reset, every source is masked, the global mask is clear, all levels and priorities are zero, `cur_level` is 0 and both vector outputs read 24. A read of any programmable source then returns 8'h80.
- R2: A programmable source whose level is 0 never wins, even when it is pending and unmasked.
- R3: A qualifying request at a higher level beats any request at a lower level, whatever their priorities are.
- R4: Inside one level, the programmable source with the higher priority wins.
- R5: External line n (`ext_req[n-1]`, source n) sits at level n. It beats programmable priorities 0 to 3 at that level and loses to priorities 4 to 7.
- R6: A winner's vector is 64 plus its source number. With no winner the vector is 24.
- R7: `ack_vector` gives the winner among qualifying sources whose level equals `ack_level`. It gives 24 when there is none, and always gives 24 when `ack_level` is 0.
- R8: A source whose mask bit is 1 does not qualify. While the global mask bit is 1, no source qualifies.
- R9: `cur_level` is registered. It shows the winner's level, or 0 with no winner, one clock edge after the requests or settings change. Both vector outputs follow the current state with no clock delay.
- R10: Requests are level-sensitive. Lowering a request line removes that source at once.
- R11: Writes of settings for sources 0 to 7 have no effect. An external line's level stays fixed, and a read of such a source shows level and priority 0.
- R12: A write with `cfg_we`=1 takes effect at the clock edge. With `cfg_sel`=0, `cfg_wdata[5:3]` sets the level and `cfg_wdata[2:0]` sets the priority. With `cfg_sel`=1, `cfg_wdata[0]` sets the source's mask bit. With `cfg_sel`=2, `cfg_wdata[0]` sets the global mask. `cfg_rdata` is {mask, 0, level[2:0], priority[2:0]} for the source `cfg_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_req | input | 7 | External request lines; bit n-1 is source n |
| int_req | input | 56 | Programmable request lines; bit k is source k+8 |
| cfg_we | input | 1 | Write strobe for the settings port |
| cfg_sel | input | 2 | Write target: 0 settings, 1 source mask, 2 global mask |
| cfg_src | input | 6 | Source addressed by write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Settings of source `cfg_src` |
| ack_level | input | 3 | Level queried by the per-level acknowledge |
| ack_vector | output | 8 | Vector of the winner at `ack_level` |
| sw_vector | output | 8 | Vector of the overall winner |
| cur_level | output | 3 | Registered level of the overall winner |

## Verification
A corrupted level, priority or mask bit shows up in the same cycle as a wrong `sw_vector` or `ack_vector`, once the affected source is pending and competing with a known rival. It shows up one edge later as a wrong `cur_level`. An error in the midpoint ranking only appears when an external line competes with programmable sources of priority 3 and 4 at the same level, so the tests build exactly that contest. A stale level register becomes visible when, under unchanged inputs, the per-level query for `cur_level` disagrees with the overall winner.

// File: rtl/lpia_pkg.sv
package lpia_pkg;
    localparam int unsigned LVL_W = 3;
    localparam int unsigned PRI_W = 3;
    // rank key: level, priority, half-step bit that places external lines mid-level
    localparam int unsigned KEY_W = LVL_W + PRI_W + 1;
    localparam logic [PRI_W:0] MID_SUB = {1'b0, {PRI_W{1'b1}}};

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MASK = 2'd1,
        SEL_MALL = 2'd2
    } cfg_sel_e;
endpackage

// File: rtl/lpia_regs.sv
module lpia_regs
    import lpia_pkg::*;
#(
    parameter int unsigned SRC_N = 64,
    parameter int unsigned EXT_N = 7,
    parameter int unsigned IDX_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [1:0]                    cfg_sel,
    input  logic [IDX_W-1:0]              cfg_src,
    input  logic [7:0]                    cfg_wdata,
    output logic [SRC_N-1:0][LVL_W-1:0]   src_lvl,
    output logic [SRC_N-1:0][PRI_W-1:0]   src_pri,
    output logic [SRC_N-1:0]              src_mask,
    output logic                          mask_all,
    output logic [7:0]                    cfg_rdata
);
    localparam logic [IDX_W-1:0] FIRST_PROG = IDX_W'(EXT_N + 1);

    typedef struct packed {
        logic [SRC_N-1:0][LVL_W-1:0] lvl;
        logic [SRC_N-1:0][PRI_W-1:0] pri;
        logic [SRC_N-1:0]            mask;
        logic                        mall;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                SEL_CTRL: if (cfg_src >= FIRST_PROG) begin
                    st_d.lvl[cfg_src] = cfg_wdata[5:3];
                    st_d.pri[cfg_src] = cfg_wdata[2:0];
                end
                SEL_MASK: if (cfg_src != '0) st_d.mask[cfg_src] = cfg_wdata[0];
                SEL_MALL: st_d.mall = cfg_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl  <= '0;
            st_q.pri  <= '0;
            st_q.mask <= '1;
            st_q.mall <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_lvl   = st_q.lvl;
    assign src_pri   = st_q.pri;
    assign src_mask  = st_q.mask;
    assign mask_all  = st_q.mall;
    assign cfg_rdata = {st_q.mask[cfg_src], 1'b0, st_q.lvl[cfg_src], st_q.pri[cfg_src]};
endmodule

// File: rtl/lpia_key.sv
module lpia_key
    import lpia_pkg::*;
#(
    parameter int unsigned SRC_N = 64,
    parameter int unsigned EXT_N = 7
) (
    input  logic [SRC_N-1:0]              req,
    input  logic [SRC_N-1:0][LVL_W-1:0]   src_lvl,
    input  logic [SRC_N-1:0][PRI_W-1:0]   src_pri,
    input  logic [SRC_N-1:0]              src_mask,
    input  logic                          mask_all,
    output logic [SRC_N-1:0][KEY_W-1:0]   key,
    output logic [SRC_N-1:0]              qual
);
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        if (i == 0) begin : g_none
            assign key[i]  = '0;
            assign qual[i] = 1'b0;
        end else if (i <= EXT_N) begin : g_ext
            localparam logic [LVL_W-1:0] FIX_LVL = LVL_W'(i);
            assign key[i]  = {FIX_LVL, MID_SUB};
            assign qual[i] = req[i] & ~src_mask[i] & ~mask_all;
        end else begin : g_prog
            assign key[i]  = {src_lvl[i], src_pri[i], 1'b0};
            assign qual[i] = req[i] & ~src_mask[i] & ~mask_all & (src_lvl[i] != '0);
        end
    end
endmodule

// File: rtl/lpia_pick.sv
module lpia_pick
    import lpia_pkg::*;
#(
    parameter int unsigned SRC_N = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic [SRC_N-1:0]              cand,
    input  logic [SRC_N-1:0][KEY_W-1:0]   key,
    output logic                          found,
    output logic [IDX_W-1:0]              win_idx,
    output logic [KEY_W-1:0]              win_key
);
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_key = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (cand[i] && (!found || key[i] > win_key)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_key = key[i];
            end
        end
    end
endmodule

// File: rtl/lpia_top.sv
module lpia_top
    import lpia_pkg::*;
#(
    parameter int unsigned SRC_N    = 64,
    parameter int unsigned EXT_N    = 7,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 64,
    parameter int unsigned VEC_SPUR = 24,
    parameter int unsigned IDX_W    = $clog2(SRC_N)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [EXT_N-1:0]           ext_req,
    input  logic [SRC_N-EXT_N-2:0]     int_req,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_sel,
    input  logic [IDX_W-1:0]           cfg_src,
    input  logic [7:0]                 cfg_wdata,
    output logic [7:0]                 cfg_rdata,
    input  logic [LVL_W-1:0]           ack_level,
    output logic [VEC_W-1:0]           ack_vector,
    output logic [VEC_W-1:0]           sw_vector,
    output logic [LVL_W-1:0]           cur_level
);
    typedef struct packed {
        logic [LVL_W-1:0] lvl;
    } top_st_t;

    logic [SRC_N-1:0]            req_all;
    logic [SRC_N-1:0][LVL_W-1:0] src_lvl;
    logic [SRC_N-1:0][PRI_W-1:0] src_pri;
    logic [SRC_N-1:0]            src_mask;
    logic                        mask_all_w;
    logic [SRC_N-1:0][KEY_W-1:0] key;
    logic [SRC_N-1:0]            qual;
    logic [SRC_N-1:0]            lvl_cand;
    logic                        all_found, lvl_found;
    logic [IDX_W-1:0]            all_idx, lvl_idx;
    logic [KEY_W-1:0]            all_key, lvl_key;
    top_st_t                     st_d, st_q;

    assign req_all = {int_req, ext_req, 1'b0};

    lpia_regs #(.SRC_N(SRC_N), .EXT_N(EXT_N), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_src(cfg_src), .cfg_wdata(cfg_wdata), .src_lvl(src_lvl),
        .src_pri(src_pri), .src_mask(src_mask), .mask_all(mask_all_w),
        .cfg_rdata(cfg_rdata)
    );

    lpia_key #(.SRC_N(SRC_N), .EXT_N(EXT_N)) u_key (
        .req(req_all), .src_lvl(src_lvl), .src_pri(src_pri),
        .src_mask(src_mask), .mask_all(mask_all_w), .key(key), .qual(qual)
    );

    for (genvar i = 0; i < SRC_N; i++) begin : g_lvl
        assign lvl_cand[i] = qual[i] & (key[i][KEY_W-1 -: LVL_W] == ack_level);
    end

    lpia_pick #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_pick_all (
        .cand(qual), .key(key), .found(all_found), .win_idx(all_idx), .win_key(all_key)
    );

    lpia_pick #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_pick_lvl (
        .cand(lvl_cand), .key(key), .found(lvl_found), .win_idx(lvl_idx), .win_key(lvl_key)
    );

    function automatic logic [VEC_W-1:0] to_vec(input logic hit, input logic [IDX_W-1:0] idx);
        return hit ? VEC_W'(VEC_BASE) + VEC_W'(idx) : VEC_W'(VEC_SPUR);
    endfunction

    assign sw_vector  = to_vec(all_found, all_idx);
    assign ack_vector = to_vec(lvl_found, lvl_idx);

    always_comb begin
        st_d     = st_q;
        st_d.lvl = all_found ? all_key[KEY_W-1 -: LVL_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_level = st_q.lvl;
endmodule

// File: rtl/lpia_chk.sv
module lpia_chk
    import lpia_pkg::*;
#(
    parameter int unsigned SRC_N    = 64,
    parameter int unsigned EXT_N    = 7,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 64,
    parameter int unsigned VEC_SPUR = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [EXT_N-1:0]       ext_req,
    input logic [SRC_N-EXT_N-2:0] int_req,
    input logic                   cfg_we,
    input logic [LVL_W-1:0]       ack_level,
    input logic [VEC_W-1:0]       ack_vector,
    input logic [VEC_W-1:0]       sw_vector,
    input logic [LVL_W-1:0]       cur_level,
    input logic                   mask_all_w
);
    localparam logic [VEC_W-1:0] SPUR = VEC_W'(VEC_SPUR);
    localparam logic [VEC_W-1:0] VLO  = VEC_W'(VEC_BASE);
    localparam logic [VEC_W-1:0] VHI  = VEC_W'(VEC_BASE + SRC_N);

    a_r8_mask_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mask_all_w |-> (sw_vector == SPUR && ack_vector == SPUR));

    a_r8_mask_all_level: assert property (@(posedge clk) disable iff (!rst_n)
        mask_all_w |=> (cur_level == '0));

    a_r7_level0_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_level == '0) |-> (ack_vector == SPUR));

    a_r7_ack_needs_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vector != SPUR) |-> (sw_vector != SPUR));

    a_r6_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_vector == SPUR) || (sw_vector > VLO && sw_vector < VHI));

    a_r9_level_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_we) && $stable(ext_req) && $stable(int_req)
         && ack_level == cur_level && sw_vector != SPUR) |-> (ack_vector == sw_vector));
endmodule

bind lpia_top lpia_chk #(
    .SRC_N(SRC_N), .EXT_N(EXT_N), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_SPUR(VEC_SPUR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .int_req(int_req), .cfg_we(cfg_we),
    .ack_level(ack_level), .ack_vector(ack_vector), .sw_vector(sw_vector),
    .cur_level(cur_level), .mask_all_w(mask_all_w)
);

// File: tb/sim_lpia_top.sv
`timescale 1ns/1ps
module sim_lpia_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ext_req = '0;
    logic [55:0] int_req = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [5:0]  cfg_src = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [2:0]  ack_level = '0;
    logic [7:0]  ack_vector, sw_vector;
    logic [2:0]  cur_level;
    int n_chk = 0, n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    lpia_top u0 (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .int_req(int_req),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_src(cfg_src), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ack_level(ack_level), .ack_vector(ack_vector),
        .sw_vector(sw_vector), .cur_level(cur_level)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; ext_req = '0; int_req = '0; cfg_we = 1'b0; ack_level = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input int src, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_src = 6'(src); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(input int src, input int lvl, input int pri);
        wr(2'd0, src, {2'b00, 3'(lvl), 3'(pri)});
        wr(2'd1, src, 8'h00);
    endtask

    task automatic ireq(input int src, input logic v);
        int_req[src-8] = v;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        apply_reset();
        #1;
        chk("R1 cur_level", cur_level, 0);
        chk("R1 sw_vector", sw_vector, 24);
        ack_level = 3'd1; #1;
        chk("R1 ack_vector", ack_vector, 24);
        cfg_src = 6'd10; #1;
        chk("R1 readback", cfg_rdata, 8'h80);
        @(negedge clk);
        wr(2'd0, 10, 8'h1A); #1;
        chk("R12 ctrl write readback", cfg_rdata, 8'h9A);
        @(negedge clk);
        wr(2'd1, 10, 8'h00); #1;
        chk("R12 mask write readback", cfg_rdata, 8'h1A);
    endtask

    task automatic t_disabled();
        apply_reset();
        prog(15, 0, 7);
        ireq(15, 1'b1);
        settle();
        chk("R2 level0 sw", sw_vector, 24);
        chk("R2 level0 cur_level", cur_level, 0);
        cfg_src = 6'd15; #1;
        chk("R2 readback", cfg_rdata, 8'h07);
    endtask

    task automatic t_levels();
        apply_reset();
        prog(10, 2, 7);
        prog(20, 5, 0);
        ireq(10, 1'b1);
        #1;
        chk("R9 ack comb", sw_vector, 74);
        settle();
        chk("R9 level after edge", cur_level, 2);
        @(negedge clk);
        ireq(20, 1'b1);
        #1;
        chk("R3 higher level wins", sw_vector, 84);
        chk("R9 level still old", cur_level, 2);
        settle();
        chk("R9 level updated", cur_level, 5);
    endtask

    task automatic t_prio();
        apply_reset();
        prog(20, 5, 0);
        prog(30, 5, 6);
        ireq(20, 1'b1); ireq(30, 1'b1);
        settle();
        chk("R4 higher priority wins", sw_vector, 94);
        chk("R6 vector 64+src", sw_vector, 64 + 30);
    endtask

    task automatic t_ext();
        apply_reset();
        prog(20, 5, 0);
        prog(30, 5, 6);
        prog(40, 5, 3);
        prog(41, 5, 4);
        wr(2'd1, 5, 8'h00);
        ext_req[4] = 1'b1; ireq(20, 1'b1); ireq(30, 1'b1);
        settle();
        chk("R5 prio6 beats ext", sw_vector, 94);
        @(negedge clk); ireq(30, 1'b0); #1;
        chk("R5 ext beats prio0", sw_vector, 69);
        @(negedge clk); ireq(40, 1'b1); #1;
        chk("R5 ext beats prio3", sw_vector, 69);
        @(negedge clk); ireq(41, 1'b1); #1;
        chk("R5 prio4 beats ext", sw_vector, 105);
        settle();
        chk("R5 ext level", cur_level, 5);
    endtask

    task automatic t_ack();
        apply_reset();
        prog(10, 2, 1);
        prog(12, 2, 5);
        prog(20, 5, 0);
        ireq(10, 1'b1); ireq(12, 1'b1); ireq(20, 1'b1);
        settle();
        ack_level = 3'd2; #1;
        chk("R7 ack level2", ack_vector, 76);
        ack_level = 3'd5; #1;
        chk("R7 ack level5", ack_vector, 84);
        ack_level = 3'd3; #1;
        chk("R7 ack empty level", ack_vector, 24);
        ack_level = 3'd0; #1;
        chk("R7 ack level0", ack_vector, 24);
        chk("R6 sw overall", sw_vector, 84);
    endtask

    task automatic t_mask();
        apply_reset();
        prog(10, 2, 1);
        prog(20, 5, 0);
        ireq(10, 1'b1); ireq(20, 1'b1);
        settle();
        chk("R8 both unmasked", sw_vector, 84);
        @(negedge clk);
        wr(2'd1, 20, 8'h01); #1;
        chk("R8 source mask", sw_vector, 74);
        settle();
        chk("R8 level after mask", cur_level, 2);
        @(negedge clk);
        wr(2'd2, 0, 8'h01); #1;
        chk("R8 mask all", sw_vector, 24);
        settle();
        chk("R8 mask all level", cur_level, 0);
        @(negedge clk);
        wr(2'd2, 0, 8'h00); #1;
        chk("R8 unmask all", sw_vector, 74);
    endtask

    task automatic t_sense();
        apply_reset();
        prog(10, 2, 1);
        ireq(10, 1'b1);
        settle();
        chk("R10 pending", sw_vector, 74);
        @(negedge clk); ireq(10, 1'b0); #1;
        chk("R10 dropped", sw_vector, 24);
        settle();
        chk("R10 level cleared", cur_level, 0);
    endtask

    task automatic t_ignored();
        apply_reset();
        wr(2'd0, 3, 8'h37);
        cfg_src = 6'd3; #1;
        chk("R11 ctrl ignored", cfg_rdata, 8'h80);
        @(negedge clk);
        wr(2'd1, 3, 8'h00);
        ext_req[2] = 1'b1;
        settle();
        chk("R11 ext vector", sw_vector, 67);
        chk("R11 ext level fixed", cur_level, 3);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_levels();
        t_prio();
        t_ext();
        t_ack();
        t_mask();
        t_sense();
        t_ignored();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule